// File: doc/BRIEF.md
# SDRAM Fixed-Slot Burst Sequencer

This block drives the command, bank and address pins of a four-bank SDRAM in a repeating time slot of constant length. The default slot is 21 clocks long. Just before each slot begins, the block asks the surrounding logic what the slot shall do: read, write, refresh or nothing. For a data slot it also takes a row address and a column base. A read or write slot opens every bank in turn and issues one auto-precharged burst of four to each bank. The activate and column commands of later banks overlap the data beats of earlier ones, so 16 data cycles per group run back to back. A build parameter adds groups of four bursts, and each group adds 16 cycles of data and 16 cycles of slot length.

After reset the block runs its own start-up. It runs refresh slots until eight refreshes have been issued, and then a slot that loads the mode register with burst length 4, sequential order and CAS latency 2. Until that slot ends, the address pins hold the mode word and take no other value. Two strobes tell the data path in which cycles it must supply write data and in which cycles read data is present. A one-cycle pulse marks the first cycle of each slot that software asked for.

Top module: `sdram_slot_seq`

## Requirements
- R1: Command pins are {cs_n,ras_n,cas_n,we_n} with NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100, REFRESH=0001, MODE SET=0000. While reset is high and in the cycle after it, the pins show NOP, bank 0 and address 0x022, and accept, slot_start, wr_req and rd_vld are low.
- R2: A slot lasts SLOT_LEN = 5 + 16*GROUPS cycles (21 by default). Accept is high for exactly one cycle, in the second-to-last pin cycle of a slot. Inputs are sampled at the clock edge that ends that cycle. Cycle 0 of the new slot appears on the pins two cycles after accept rises, and slot_start is high in that cycle only.
- R3: After reset is released, the first pin cycle carries REFRESH. Eight slots each carry REFRESH in cycle 0 and NOP elsewhere. The ninth slot carries MODE SET with bank 0 in cycle 0. The first accept falls in that ninth slot.
- R4: The address pins stay at 0x022 (burst length 4 in bits 2:0, CAS latency 2 in bits 6:4) from reset until the mode-set slot has ended.
- R5: Slot kind 1 (read): burst k (0..4*GROUPS-1) gives ACTIVE at cycle 4k on bank k mod 4 with address = row. It gives READ at cycle 4k+2 on the same bank with address = column | 0x400 (bit 10 = auto-precharge). The column is col_base*4*GROUPS + 4*(k div 4). All other cycles are NOP.
- R6: Slot kind 2 (write) follows the same schedule as R5, with WRITE in place of READ.
- R7: wr_req is high in cycles 2 to 16*GROUPS+1 of write slots and at no other time. It is never high together with rd_vld.
- R8: rd_vld is high in cycles 4 to 16*GROUPS+3 of read slots and at no other time.
- R9: Slot kind 3 (refresh) carries REFRESH in cycle 0 and NOP in every other cycle, with both strobes low.
- R10: Slot kind 0 (idle) carries NOP in every cycle. The bank and address pins keep the last value driven by an ACTIVE, READ or WRITE.
- R11: Changes to slot_kind, row_addr or col_base outside the sampling edge have no effect on the slot in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_kind | input | 2 | Next slot: 0 idle, 1 read, 2 write, 3 refresh |
| row_addr | input | ADDR_W | Row opened in every bank for a data slot |
| col_base | input | COLB_W | Column base of the burst group |
| accept | output | 1 | Inputs are sampled at the edge that ends this cycle |
| slot_start | output | 1 | First pin cycle of a requested slot |
| wr_req | output | 1 | Drive one write word this cycle |
| rd_vld | output | 1 | One read word is present this cycle |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | ADDR_W | Multiplexed address |

## Verification
Every pin output is registered one cycle after the slot counter, so a request sampled at the end of an accept cycle shows cycle 0 on the pins two clocks later. Each later slot cycle p then appears p clocks after that. The bench drives inputs and samples outputs on the falling edge. It waits one cycle for the sampling edge and one more for the pin register, and then compares every pin cycle of the slot against a schedule computed from the slot position. The start-up trace is anchored on the first pin cycle after reset release and is compared cycle by cycle through the mode-set slot.

// File: rtl/sdram_slot_pkg.sv
package sdram_slot_pkg;

  typedef logic [3:0] cmd_t; // {cs_n, ras_n, cas_n, we_n}

  localparam cmd_t CMD_NOP  = 4'b0111;
  localparam cmd_t CMD_ACT  = 4'b0011;
  localparam cmd_t CMD_RD   = 4'b0101;
  localparam cmd_t CMD_WR   = 4'b0100;
  localparam cmd_t CMD_REF  = 4'b0001;
  localparam cmd_t CMD_MRS  = 4'b0000;

  typedef enum logic [1:0] {
    SK_IDLE    = 2'd0,
    SK_READ    = 2'd1,
    SK_WRITE   = 2'd2,
    SK_REFRESH = 2'd3
  } slot_kind_e;

  typedef enum logic [2:0] {
    EK_IDLE,
    EK_READ,
    EK_WRITE,
    EK_REFRESH,
    EK_MODE
  } exec_kind_e;

  typedef enum logic [1:0] {
    PH_REFRESH,
    PH_MODE,
    PH_RUN
  } phase_e;

endpackage

// File: rtl/sdram_slot_timer.sv
module sdram_slot_timer #(
  parameter int SLOT_LEN = 21,
  parameter int POS_W    = $clog2(SLOT_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [POS_W-1:0] pos,
  output logic             at_last,
  output logic             at_prelast
);
  localparam logic [POS_W-1:0] LAST    = POS_W'(SLOT_LEN - 1);
  localparam logic [POS_W-1:0] PRELAST = POS_W'(SLOT_LEN - 2);

  assign at_last    = (pos == LAST);
  assign at_prelast = (pos == PRELAST);

  always_ff @(posedge clk) begin
    if (rst)          pos <= '0;
    else if (at_last) pos <= '0;
    else              pos <= pos + 1'b1;
  end

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (pos == LAST) |=> (pos == '0));
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (pos != LAST) |=> (pos == $past(pos) + 1'b1));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_slot_pkg::*;
#(
  parameter int INIT_REFS = 8
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   wrap,
  output phase_e phase
);
  localparam int RC_W = $clog2(INIT_REFS + 1);
  localparam logic [RC_W-1:0] RC_LAST = RC_W'(INIT_REFS - 1);
  localparam logic [RC_W-1:0] RC_DONE = RC_W'(INIT_REFS);

  logic [RC_W-1:0] ref_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_REFRESH;
      ref_cnt <= '0;
    end else if (wrap) begin
      case (phase)
        PH_REFRESH: begin
          ref_cnt <= ref_cnt + 1'b1;
          if (ref_cnt == RC_LAST) phase <= PH_MODE;
        end
        PH_MODE: phase <= PH_RUN;
        default: ;
      endcase
    end
  end

  p_mode_after_refs_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MODE) |-> (ref_cnt == RC_DONE));
  p_run_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RUN) |=> (phase == PH_RUN));

endmodule

// File: rtl/sdram_slot_decode.sv
module sdram_slot_decode
  import sdram_slot_pkg::*;
#(
  parameter int GROUPS = 1,
  parameter int ADDR_W = 13,
  parameter int COL_W  = 10,
  parameter int COLB_W = 8,
  parameter int POS_W  = 5
) (
  input  logic [POS_W-1:0]  pos,
  input  exec_kind_e        kind,
  input  logic [ADDR_W-1:0] row,
  input  logic [COLB_W-1:0] colb,
  output cmd_t              cmd,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] av,
  output logic              ld,
  output logic              wr_on,
  output logic              rd_on
);
  localparam int DATA_CYC = 16 * GROUPS;
  localparam int BURSTS   = 4 * GROUPS;
  localparam int AP_BIT   = 10;
  localparam logic [POS_W-1:0] DATA_END = POS_W'(DATA_CYC);
  localparam logic [POS_W-1:0] WR_LO    = POS_W'(2);
  localparam logic [POS_W-1:0] WR_HI    = POS_W'(DATA_CYC + 1);
  localparam logic [POS_W-1:0] RD_LO    = POS_W'(4);
  localparam logic [POS_W-1:0] RD_HI    = POS_W'(DATA_CYC + 3);
  localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

  logic [POS_W-1:0] burst;
  logic [POS_W-1:0] grp;
  logic [COL_W-1:0] colv;

  assign burst = pos >> 2;
  assign grp   = burst >> 2;
  assign colv  = COL_W'(colb) * COL_W'(BURSTS) + COL_W'(grp) * COL_W'(4);

  always_comb begin
    cmd = CMD_NOP;
    ba  = '0;
    av  = '0;
    ld  = 1'b0;
    case (kind)
      EK_READ, EK_WRITE: begin
        if (pos < DATA_END) begin
          if (pos[1:0] == 2'd0) begin
            cmd = CMD_ACT;
            ba  = burst[1:0];
            av  = row;
            ld  = 1'b1;
          end else if (pos[1:0] == 2'd2) begin
            cmd = (kind == EK_READ) ? CMD_RD : CMD_WR;
            ba  = burst[1:0];
            av  = ADDR_W'(colv) | AP_MASK;
            ld  = 1'b1;
          end
        end
      end
      EK_REFRESH: if (pos == '0) cmd = CMD_REF;
      EK_MODE:    if (pos == '0) cmd = CMD_MRS;
      default: ;
    endcase
  end

  assign wr_on = (kind == EK_WRITE) && (pos >= WR_LO) && (pos <= WR_HI);
  assign rd_on = (kind == EK_READ)  && (pos >= RD_LO) && (pos <= RD_HI);

endmodule

// File: rtl/sdram_slot_seq.sv
module sdram_slot_seq
  import sdram_slot_pkg::*;
#(
  parameter int GROUPS    = 1,
  parameter int ADDR_W    = 13,
  parameter int COL_W     = 10,
  parameter int COLB_W    = 8,
  parameter int INIT_REFS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        slot_kind,
  input  logic [ADDR_W-1:0] row_addr,
  input  logic [COLB_W-1:0] col_base,
  output logic              accept,
  output logic              slot_start,
  output logic              wr_req,
  output logic              rd_vld,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [1:0]        sd_ba,
  output logic [ADDR_W-1:0] sd_addr
);
  localparam int SLOT_LEN = 5 + 16 * GROUPS;
  localparam int POS_W    = $clog2(SLOT_LEN);
  localparam logic [ADDR_W-1:0] MODE_VAL = ADDR_W'(7'b010_0_010);

  logic [POS_W-1:0]  pos;
  logic              wrap;
  logic              pre_wrap;
  phase_e            phase;
  slot_kind_e        kind_q;
  logic [ADDR_W-1:0] row_q;
  logic [COLB_W-1:0] colb_q;
  exec_kind_e        ek;
  cmd_t              dec_cmd;
  logic [1:0]        dec_ba;
  logic [ADDR_W-1:0] dec_av;
  logic              dec_ld;
  logic              dec_wr;
  logic              dec_rd;
  cmd_t              pin_cmd;

  sdram_slot_timer #(.SLOT_LEN(SLOT_LEN), .POS_W(POS_W)) u_timer (
    .clk(clk), .rst(rst), .pos(pos), .at_last(wrap), .at_prelast(pre_wrap)
  );

  sdram_init_seq #(.INIT_REFS(INIT_REFS)) u_init (
    .clk(clk), .rst(rst), .wrap(wrap), .phase(phase)
  );

  // request capture: only at the edge that closes the accept cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= SK_IDLE;
      row_q  <= '0;
      colb_q <= '0;
    end else if (wrap && phase != PH_REFRESH) begin
      kind_q <= slot_kind_e'(slot_kind);
      row_q  <= row_addr;
      colb_q <= col_base;
    end
  end

  always_comb begin
    case (phase)
      PH_REFRESH: ek = EK_REFRESH;
      PH_MODE:    ek = EK_MODE;
      default: begin
        case (kind_q)
          SK_READ:    ek = EK_READ;
          SK_WRITE:   ek = EK_WRITE;
          SK_REFRESH: ek = EK_REFRESH;
          default:    ek = EK_IDLE;
        endcase
      end
    endcase
  end

  sdram_slot_decode #(
    .GROUPS(GROUPS), .ADDR_W(ADDR_W), .COL_W(COL_W),
    .COLB_W(COLB_W), .POS_W(POS_W)
  ) u_decode (
    .pos(pos), .kind(ek), .row(row_q), .colb(colb_q),
    .cmd(dec_cmd), .ba(dec_ba), .av(dec_av), .ld(dec_ld),
    .wr_on(dec_wr), .rd_on(dec_rd)
  );

  // pin registers; address/bank are clock-enabled only after mode set
  always_ff @(posedge clk) begin
    if (rst) begin
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= CMD_NOP;
      sd_ba      <= '0;
      sd_addr    <= MODE_VAL;
      wr_req     <= 1'b0;
      rd_vld     <= 1'b0;
      accept     <= 1'b0;
      slot_start <= 1'b0;
    end else begin
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= dec_cmd;
      if (dec_ld && phase == PH_RUN) begin
        sd_ba   <= dec_ba;
        sd_addr <= dec_av;
      end
      wr_req     <= dec_wr;
      rd_vld     <= dec_rd;
      accept     <= pre_wrap && (phase != PH_REFRESH);
      slot_start <= (pos == '0) && (phase == PH_RUN);
    end
  end

  assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  p_act_cas_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(pin_cmd, 2) == CMD_ACT) |->
      ((pin_cmd == CMD_RD || pin_cmd == CMD_WR) && sd_ba == $past(sd_ba, 2)));
  p_addr_mode_r4: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_RUN) |-> (sd_addr == MODE_VAL));
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(wr_req && rd_vld));
  p_accept_start_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> ##1 slot_start);
  p_accept_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> !accept);

endmodule

// File: tb/sdram_slot_seq_bench.sv
module sdram_slot_seq_bench;
  localparam int GROUPS = 1;
  localparam int ADDR_W = 13;
  localparam int COLB_W = 8;
  localparam int SLOT   = 5 + 16 * GROUPS;
  localparam int LASTP  = SLOT - 1;
  localparam int MODE   = 'h022;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_REF = 4'b0001, C_MRS = 4'b0000;

  // {kind[1:0], row[12:0], col_base[7:0], scramble}
  localparam logic [23:0] VEC [8] = '{
    {2'd1, 13'h0123, 8'h00, 1'b0},
    {2'd2, 13'h1FFF, 8'hFF, 1'b0},
    {2'd3, 13'h0AAA, 8'h11, 1'b0},
    {2'd0, 13'h0555, 8'h22, 1'b0},
    {2'd2, 13'h0000, 8'h01, 1'b1},
    {2'd1, 13'h1555, 8'h80, 1'b1},
    {2'd1, 13'h0F0F, 8'h7E, 1'b0},
    {2'd0, 13'h0000, 8'h00, 1'b1}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst;
  logic [1:0]        slot_kind;
  logic [ADDR_W-1:0] row_addr;
  logic [COLB_W-1:0] col_base;
  logic accept, slot_start, wr_req, rd_vld;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]        sd_ba;
  logic [ADDR_W-1:0] sd_addr;

  sdram_slot_seq u_sdram_slot_seq (
    .clk(clk), .rst(rst), .slot_kind(slot_kind), .row_addr(row_addr),
    .col_base(col_base), .accept(accept), .slot_start(slot_start),
    .wr_req(wr_req), .rd_vld(rd_vld), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
  );

  int checks = 0;
  int errors = 0;
  int exp_ba = 0;
  int exp_addr = MODE;

  function automatic logic [3:0] pins();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic chk_reset_state();
    chk("R1 reset cmd", int'(pins()), int'(C_NOP));
    chk("R1 reset bank", int'(sd_ba), 0);
    chk("R1 reset addr", int'(sd_addr), MODE);
    chk("R1 reset strobes", int'({accept, slot_start, wr_req, rd_vld}), 0);
  endtask

  // one requested slot; entered at a falling edge with accept high
  task automatic run_slot(input int kind, input int row, input int colb, input bit scr);
    string tag;
    int ecmd, ewr, erd, k;
    slot_kind = 2'(kind);
    row_addr  = ADDR_W'(row);
    col_base  = COLB_W'(colb);
    @(negedge clk);
    if (scr) begin
      slot_kind = ~slot_kind;
      row_addr  = ~row_addr;
      col_base  = ~col_base;
    end
    chk("R2 last slot cycle nop", int'(pins()), int'(C_NOP));
    @(negedge clk);
    tag = scr ? "R11" : (kind == 1) ? "R5" : (kind == 2) ? "R6" :
          (kind == 3) ? "R9" : "R10";
    for (int p = 0; p < LASTP; p++) begin
      ecmd = C_NOP;
      if ((kind == 1 || kind == 2) && p < 16 * GROUPS) begin
        k = p / 4;
        if (p % 4 == 0) begin
          ecmd = C_ACT; exp_ba = k % 4; exp_addr = row;
        end else if (p % 4 == 2) begin
          ecmd = (kind == 1) ? C_RD : C_WR; exp_ba = k % 4;
          exp_addr = ((colb * 4 * GROUPS + 4 * (k / 4)) % 1024) | 'h400;
        end
      end else if (kind == 3 && p == 0) begin
        ecmd = C_REF;
      end
      ewr = (kind == 2 && p >= 2 && p <= 16 * GROUPS + 1) ? 1 : 0;
      erd = (kind == 1 && p >= 4 && p <= 16 * GROUPS + 3) ? 1 : 0;
      chk($sformatf("%s cmd p=%0d", tag, p), int'(pins()), ecmd);
      chk($sformatf("%s bank p=%0d", tag, p), int'(sd_ba), exp_ba);
      chk($sformatf("%s addr p=%0d", tag, p), int'(sd_addr), exp_addr);
      chk($sformatf("R7 wr_req p=%0d", p), int'(wr_req), ewr);
      chk($sformatf("R8 rd_vld p=%0d", p), int'(rd_vld), erd);
      chk($sformatf("R2 slot_start p=%0d", p), int'(slot_start), (p == 0) ? 1 : 0);
      chk($sformatf("R2 accept p=%0d", p), int'(accept), (p == LASTP - 1) ? 1 : 0);
      if (p < LASTP - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual hung expected progress");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ecmd;
    rst = 1'b1; slot_kind = '0; row_addr = '0; col_base = '0;
    repeat (3) @(negedge clk);
    chk_reset_state();
    rst = 1'b0;
    @(negedge clk);
    // start-up trace: 8 refresh slots, then mode set
    for (int i = 0; i <= 9 * SLOT - 2; i++) begin
      ecmd = (i % SLOT != 0) ? C_NOP : (i / SLOT < 8) ? C_REF : C_MRS;
      chk($sformatf("R3 init cmd i=%0d", i), int'(pins()), ecmd);
      chk($sformatf("R4 init addr i=%0d", i), int'(sd_addr), MODE);
      chk($sformatf("R3 init bank i=%0d", i), int'(sd_ba), 0);
      chk($sformatf("R3 init accept i=%0d", i), int'(accept), (i == 9 * SLOT - 2) ? 1 : 0);
      if (i < 9 * SLOT - 2) @(negedge clk);
    end
    exp_ba = 0; exp_addr = MODE;
    for (int v = 0; v < 8; v++) begin
      run_slot(int'(VEC[v][23:22]), int'(VEC[v][21:9]), int'(VEC[v][8:1]), VEC[v][0]);
    end
    // reset in the middle of traffic
    slot_kind = 2'd2; row_addr = 13'h0ABC; col_base = 8'h05;
    @(negedge clk);
    repeat (7) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk_reset_state();
    rst = 1'b0;
    @(negedge clk);
    chk("R3 first cycle after reset release", int'(pins()), int'(C_REF));
    chk("R4 addr after reset release", int'(sd_addr), MODE);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule